// File: doc/BRIEF.md
# Two-Level Page Walker

This block turns a 32-bit linear address into a physical address by reading a two-level table held in memory. A requester gives a linear address, an access type (read or write) and the frame number of the root directory. The walker then fetches one directory word and, when needed, one table word over a word-read port with valid/ready on the request side and a valid strobe on the response side. It reports either the physical address or a fault with a cause code.

Pages are either 4 KiB or 4 MiB. A directory word with its large-page flag set ends the walk at the first level. A write is allowed only when the writable flags of every level on the walk are set. The walker handles one request at a time. It does not update entries, cache results, or support wider entry formats.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready_o` is high only while no walk is in progress. After a request is accepted it stays low until the result pulse of that walk.
- R2: The first memory read is at `{base_frame_i, 12'h000} + 4 * lin[31:22]`.
- R3: For a small-page walk, the second read is at `{dir_word[31:12], 12'h000} + 4 * lin[21:12]`.
- R4: A successful small-page walk returns `{tbl_word[31:12], lin[11:0]}`.
- R5: If bit 7 of a present directory word is set, the walk does exactly one memory read and returns `{dir_word[31:22], lin[21:0]}`.
- R6: Bit 0 of each entry is the present flag. A clear flag in the directory word gives cause 1 with no second read. A clear flag in the table word gives cause 2.
- R7: Bit 1 of each entry is the writable flag. A write faults with cause 3 when the AND of bit 1 over the entries read is 0. A read never faults with cause 3.
- R8: Each walk ends in exactly one one-cycle `res_valid_o` pulse. On a fault, `res_fault_o` is 1 and `res_paddr_o` is 0. On success, `res_fault_o` is 0 and the cause is 0.
- R9: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_frame_i | input | 20 | Frame number of the root directory, sampled at request acceptance |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_addr_i | input | 32 | Linear address to translate |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| mem_req_valid_o | output | 1 | Word read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 32 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Entry word returned by memory |
| res_valid_o | output | 1 | One-cycle result pulse |
| res_fault_o | output | 1 | Walk ended in a fault |
| res_cause_o | output | 2 | 0 none, 1 directory not present, 2 table not present, 3 write protect |
| res_paddr_o | output | 32 | Translated physical address (0 on fault) |

## Verification
Directed walks come first. They reuse a known translation, then try a read-only leaf with both access types, a zero linear address over an empty directory, an absent table word, and large pages that are writable and read-only. Another case clears the writable flag only at the directory level, which shows that the permission is a two-level AND and not a leaf-only check. Random walks follow, with random present, large and writable flags and random memory stall and response delays. They confirm that the entry addresses, the read count and the result do not depend on handshake timing. Each result is compared with a bench model of the address split.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DIR_REQ, S_DIR_WAIT, S_TBL_REQ, S_TBL_WAIT
  } walk_state_t;

  typedef enum logic [1:0] {
    C_NONE   = 2'd0,
    C_DIR_NP = 2'd1,
    C_TBL_NP = 2'd2,
    C_WPROT  = 2'd3
  } fault_cause_t;
endpackage

// File: rtl/ptw_addr_gen.sv
// Entry addresses and final physical addresses from latched walk state.
module ptw_addr_gen #(
  parameter int DIR_BITS = 10,
  parameter int TBL_BITS = 10,
  parameter int OFF_BITS = 12
) (
  input  logic [DIR_BITS+TBL_BITS-1:0]          root_frame_i,
  input  logic [DIR_BITS+TBL_BITS-1:0]          pde_frame_i,
  input  logic [DIR_BITS+TBL_BITS-1:0]          leaf_frame_i,
  input  logic [DIR_BITS+TBL_BITS+OFF_BITS-1:0] lin_i,
  output logic [DIR_BITS+TBL_BITS+OFF_BITS-1:0] dir_addr_o,
  output logic [DIR_BITS+TBL_BITS+OFF_BITS-1:0] tbl_addr_o,
  output logic [DIR_BITS+TBL_BITS+OFF_BITS-1:0] page_pa_o,
  output logic [DIR_BITS+TBL_BITS+OFF_BITS-1:0] big_pa_o
);
  localparam int AW        = DIR_BITS + TBL_BITS + OFF_BITS;
  localparam int ENT_SHIFT = 2;
  localparam int LOW_BITS  = TBL_BITS + OFF_BITS;

  logic [DIR_BITS-1:0] dir_idx;
  logic [TBL_BITS-1:0] tbl_idx;

  assign dir_idx = lin_i[AW-1 -: DIR_BITS];
  assign tbl_idx = lin_i[LOW_BITS-1 -: TBL_BITS];

  assign dir_addr_o = {root_frame_i, {OFF_BITS{1'b0}}} + (AW'(dir_idx) << ENT_SHIFT);
  assign tbl_addr_o = {pde_frame_i,  {OFF_BITS{1'b0}}} + (AW'(tbl_idx) << ENT_SHIFT);
  assign page_pa_o  = {leaf_frame_i, lin_i[OFF_BITS-1:0]};
  assign big_pa_o   = {leaf_frame_i[DIR_BITS+TBL_BITS-1 -: DIR_BITS], lin_i[LOW_BITS-1:0]};
endmodule

// File: rtl/ptw_entry_check.sv
// Decodes the attribute field of one entry against the access type.
module ptw_entry_check #(
  parameter int OFF_BITS = 12,
  parameter int P_BIT    = 0,
  parameter int RW_BIT   = 1,
  parameter int PS_BIT   = 7
) (
  input  logic [OFF_BITS-1:0] attr_i,
  input  logic                upper_rw_i,
  input  logic                is_write_i,
  output logic                present_o,
  output logic                large_o,
  output logic                wp_fault_o
);
  logic unused_attr;
  assign unused_attr = ^attr_i;

  assign present_o  = attr_i[P_BIT];
  assign large_o    = attr_i[PS_BIT];
  assign wp_fault_o = is_write_i & ~(upper_rw_i & attr_i[RW_BIT]);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int DIR_BITS = 10,
  parameter int TBL_BITS = 10,
  parameter int OFF_BITS = 12,
  parameter int P_BIT    = 0,
  parameter int RW_BIT   = 1,
  parameter int PS_BIT   = 7
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [DIR_BITS+TBL_BITS-1:0]          base_frame_i,
  input  logic                                  req_valid_i,
  output logic                                  req_ready_o,
  input  logic [DIR_BITS+TBL_BITS+OFF_BITS-1:0] req_addr_i,
  input  logic                                  req_write_i,
  output logic                                  mem_req_valid_o,
  input  logic                                  mem_req_ready_i,
  output logic [DIR_BITS+TBL_BITS+OFF_BITS-1:0] mem_req_addr_o,
  input  logic                                  mem_rsp_valid_i,
  input  logic [DIR_BITS+TBL_BITS+OFF_BITS-1:0] mem_rsp_data_i,
  output logic                                  res_valid_o,
  output logic                                  res_fault_o,
  output logic [1:0]                            res_cause_o,
  output logic [DIR_BITS+TBL_BITS+OFF_BITS-1:0] res_paddr_o
);
  import ptw_pkg::*;

  localparam int AW = DIR_BITS + TBL_BITS + OFF_BITS;
  localparam int FW = DIR_BITS + TBL_BITS;

  walk_state_t  state_q;
  logic [AW-1:0] lin_q;
  logic          wr_q;
  logic [FW-1:0] root_q;
  logic [FW-1:0] pde_frame_q;
  logic          pde_rw_q;

  logic          res_valid_q, res_fault_q;
  fault_cause_t  res_cause_q;
  logic [AW-1:0] res_pa_q;

  logic [AW-1:0] dir_addr, tbl_addr, page_pa, big_pa;
  logic d_present, d_large, d_wp;
  logic t_present, t_large, t_wp;
  logic unused_t_large;

  logic          fin;
  fault_cause_t  fin_cause;
  logic [AW-1:0] fin_pa;

  ptw_addr_gen #(.DIR_BITS(DIR_BITS), .TBL_BITS(TBL_BITS), .OFF_BITS(OFF_BITS)) u_addr (
    .root_frame_i (root_q),
    .pde_frame_i  (pde_frame_q),
    .leaf_frame_i (mem_rsp_data_i[AW-1:OFF_BITS]),
    .lin_i        (lin_q),
    .dir_addr_o   (dir_addr),
    .tbl_addr_o   (tbl_addr),
    .page_pa_o    (page_pa),
    .big_pa_o     (big_pa)
  );

  // Directory level: nothing above it, so the upper permission is open.
  ptw_entry_check #(.OFF_BITS(OFF_BITS), .P_BIT(P_BIT), .RW_BIT(RW_BIT), .PS_BIT(PS_BIT)) u_dir_chk (
    .attr_i     (mem_rsp_data_i[OFF_BITS-1:0]),
    .upper_rw_i (1'b1),
    .is_write_i (wr_q),
    .present_o  (d_present),
    .large_o    (d_large),
    .wp_fault_o (d_wp)
  );

  // Table level: permission is ANDed with the latched directory flag.
  ptw_entry_check #(.OFF_BITS(OFF_BITS), .P_BIT(P_BIT), .RW_BIT(RW_BIT), .PS_BIT(PS_BIT)) u_tbl_chk (
    .attr_i     (mem_rsp_data_i[OFF_BITS-1:0]),
    .upper_rw_i (pde_rw_q),
    .is_write_i (wr_q),
    .present_o  (t_present),
    .large_o    (t_large),
    .wp_fault_o (t_wp)
  );
  assign unused_t_large = t_large;

  always_comb begin
    fin       = 1'b0;
    fin_cause = C_NONE;
    fin_pa    = '0;
    if (state_q == S_DIR_WAIT && mem_rsp_valid_i) begin
      if (!d_present) begin
        fin       = 1'b1;
        fin_cause = C_DIR_NP;
      end else if (d_large) begin
        fin = 1'b1;
        if (d_wp) fin_cause = C_WPROT;
        else      fin_pa    = big_pa;
      end
    end
    if (state_q == S_TBL_WAIT && mem_rsp_valid_i) begin
      fin = 1'b1;
      if (!t_present)  fin_cause = C_TBL_NP;
      else if (t_wp)   fin_cause = C_WPROT;
      else             fin_pa    = page_pa;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      lin_q       <= '0;
      wr_q        <= 1'b0;
      root_q      <= '0;
      pde_frame_q <= '0;
      pde_rw_q    <= 1'b0;
      res_valid_q <= 1'b0;
      res_fault_q <= 1'b0;
      res_cause_q <= C_NONE;
      res_pa_q    <= '0;
    end else begin
      res_valid_q <= 1'b0;
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          lin_q   <= req_addr_i;
          wr_q    <= req_write_i;
          root_q  <= base_frame_i;
          state_q <= S_DIR_REQ;
        end
        S_DIR_REQ: if (mem_req_ready_i) state_q <= S_DIR_WAIT;
        S_DIR_WAIT: if (mem_rsp_valid_i) begin
          pde_frame_q <= mem_rsp_data_i[AW-1:OFF_BITS];
          pde_rw_q    <= mem_rsp_data_i[RW_BIT];
          if (!fin) state_q <= S_TBL_REQ;
        end
        S_TBL_REQ: if (mem_req_ready_i) state_q <= S_TBL_WAIT;
        S_TBL_WAIT: ;
        default: state_q <= S_IDLE;
      endcase
      if (fin) begin
        state_q     <= S_IDLE;
        res_valid_q <= 1'b1;
        res_fault_q <= (fin_cause != C_NONE);
        res_cause_q <= fin_cause;
        res_pa_q    <= fin_pa;
      end
    end
  end

  assign req_ready_o     = (state_q == S_IDLE);
  assign mem_req_valid_o = (state_q == S_DIR_REQ) || (state_q == S_TBL_REQ);
  assign mem_req_addr_o  = (state_q == S_TBL_REQ) ? tbl_addr : dir_addr;
  assign res_valid_o     = res_valid_q;
  assign res_fault_o     = res_fault_q;
  assign res_cause_o     = res_cause_q;
  assign res_paddr_o     = res_pa_q;

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && req_ready_o |=> !req_ready_o);
  a_r1_no_mem_when_idle: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid_o |-> !req_ready_o);
  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));
  a_r6_dir_absent_ends: assert property (@(posedge clk) disable iff (rst)
    state_q == S_DIR_WAIT && mem_rsp_valid_i && !mem_rsp_data_i[P_BIT] |=> res_valid_o && state_q == S_IDLE);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |=> !res_valid_o);
  a_r8_fault_no_pa: assert property (@(posedge clk) disable iff (rst)
    res_valid_o && res_fault_o |-> res_paddr_o == '0 && res_cause_o != 2'd0);
  a_r8_ok_no_cause: assert property (@(posedge clk) disable iff (rst)
    res_valid_o && !res_fault_o |-> res_cause_o == 2'd0);
  a_r7_read_never_wp: assert property (@(posedge clk) disable iff (rst)
    res_valid_o && res_cause_o == 2'd3 |-> wr_q);
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] base_frame_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        res_valid_o;
  logic        res_fault_o;
  logic [1:0]  res_cause_o;
  logic [31:0] res_paddr_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  ptw_walker dut (
    .clk(clk), .rst(rst), .base_frame_i(base_frame_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_write_i(req_write_i),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i), .res_valid_o(res_valid_o),
    .res_fault_o(res_fault_o), .res_cause_o(res_cause_o), .res_paddr_o(res_paddr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  // Bench model of the two-level walk.
  task automatic model(input logic [31:0] base, la, input bit wr, input logic [31:0] pde, pte,
                       output logic [1:0] cause, output logic [31:0] pa, output int reads,
                       output logic [31:0] a1, output logic [31:0] a2, output string tag);
    a1 = {base[31:12], 12'h000} + {20'h0, la[31:22], 2'b00};
    a2 = {pde[31:12], 12'h000} + {20'h0, la[21:12], 2'b00};
    pa = '0;
    cause = 2'd0;
    if (!pde[0]) begin
      reads = 1; cause = 2'd1; tag = "R6";
    end else if (pde[7]) begin
      reads = 1; tag = "R5";
      if (wr && !pde[1]) begin cause = 2'd3; tag = "R7"; end
      else pa = {pde[31:22], la[21:0]};
    end else begin
      reads = 2; tag = "R4";
      if (!pte[0]) begin cause = 2'd2; tag = "R6"; end
      else if (wr && !(pde[1] & pte[1])) begin cause = 2'd3; tag = "R7"; end
      else pa = {pte[31:12], la[11:0]};
    end
  endtask

  task automatic do_walk(input logic [31:0] base, la, input bit wr, input logic [31:0] pde, pte);
    logic [1:0]  e_cause;
    logic [31:0] e_pa, e_a1, e_a2;
    int          e_reads;
    string       tag;
    int          reads = 0;
    bit          pending = 1'b0;
    bit          got = 1'b0;
    logic        g_fault = 1'b0;
    logic [1:0]  g_cause = '0;
    logic [31:0] g_pa = '0;
    model(base, la, wr, pde, pte, e_cause, e_pa, e_reads, e_a1, e_a2, tag);
    @(negedge clk);
    check(req_ready_o == 1'b1, "R1 idle ready", {31'h0, req_ready_o}, 32'h1);
    base_frame_i = base[31:12];
    req_addr_i   = la;
    req_write_i  = wr;
    req_valid_i  = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    req_addr_i  = $urandom;
    check(req_ready_o == 1'b0, "R1 busy", {31'h0, req_ready_o}, 32'h0);
    for (int c = 0; c < 200 && !got; c++) begin
      if (res_valid_o) begin
        got = 1'b1;
        g_fault = res_fault_o;
        g_cause = res_cause_o;
        g_pa = res_paddr_o;
      end else if (pending && ($urandom % 3) != 0) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = (reads == 1) ? pde : pte;
        pending = 1'b0;
      end else if (mem_req_valid_o && !pending && ($urandom % 3) != 0) begin
        mem_req_ready_i = 1'b1;
        reads++;
        if (reads == 1) check(mem_req_addr_o == e_a1, "R2 dir addr", mem_req_addr_o, e_a1);
        else            check(mem_req_addr_o == e_a2, "R3 tbl addr", mem_req_addr_o, e_a2);
        pending = 1'b1;
      end
      @(negedge clk);
      mem_req_ready_i = 1'b0;
      mem_rsp_valid_i = 1'b0;
      mem_rsp_data_i  = $urandom;
    end
    check(got, "R8 result seen", {31'h0, got}, 32'h1);
    check(res_valid_o == 1'b0, "R8 one-cycle pulse", {31'h0, res_valid_o}, 32'h0);
    check(reads == e_reads, "R5 R6 read count", reads, e_reads);
    check(g_cause == e_cause, {tag, " cause"}, {30'h0, g_cause}, {30'h0, e_cause});
    check(g_fault == (e_cause != 2'd0), "R8 fault flag", {31'h0, g_fault}, {31'h0, e_cause != 2'd0});
    check(g_pa == e_pa, {tag, " paddr"}, g_pa, e_pa);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(req_ready_o == 1'b1, "R1 reset ready", {31'h0, req_ready_o}, 32'h1);
    check(res_valid_o == 1'b0, "R8 reset no result", {31'h0, res_valid_o}, 32'h0);
    check(mem_req_valid_o == 1'b0, "R9 reset no mem req", {31'h0, mem_req_valid_o}, 32'h0);

    // R2 R3 R4 known translation
    do_walk(32'h1A3C9000, 32'h00425A30, 1'b0, 32'h19F1D067, 32'h1A286067);
    do_walk(32'h1A3C9000, 32'h00425A30, 1'b1, 32'h19F1D067, 32'h1A286067);
    // R7 read-only leaf: read passes, write faults
    do_walk(32'h0DE1D000, 32'h00423020, 1'b0, 32'h0B925067, 32'h03014025);
    do_walk(32'h0DE1D000, 32'h00423020, 1'b1, 32'h0B925067, 32'h03014025);
    // R7 AND across levels: directory read-only, leaf writable
    do_walk(32'h0DE1D000, 32'h00423020, 1'b1, 32'h0B925065, 32'h03014067);
    // R6 address zero, empty directory; absent table word
    do_walk(32'h1A3C9000, 32'h00000000, 1'b0, 32'h00000000, 32'h1A286067);
    do_walk(32'h1A3C9000, 32'hFFC01234, 1'b1, 32'h19F1D067, 32'h1A286066);
    // R5 large pages: writable, read-only write, read-only read
    do_walk(32'h00001000, 32'hABCDE123, 1'b1, 32'h12C000E7, 32'h0);
    do_walk(32'h00001000, 32'h7FFFFFFF, 1'b1, 32'hFFC000E5, 32'h0);
    do_walk(32'h00001000, 32'h7FFFFFFF, 1'b0, 32'hFFC000E5, 32'h0);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] pde, pte;
      pde = $urandom;
      pte = $urandom;
      pde[0] = ($urandom % 8) != 0;
      pde[7] = ($urandom % 4) == 0;
      pde[1] = ($urandom % 3) != 0;
      pte[0] = ($urandom % 6) != 0;
      pte[1] = ($urandom % 3) != 0;
      do_walk($urandom, $urandom, 1'($urandom), pde, pte);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule